// File: doc/BRIEF.md
# Single-Compare 8-bit Timer with PWM

This block is an 8-bit timer/counter with a single compare register and one waveform output. It offers three counting modes. Free-running overflow counting is the first. The second is an auto-reload mode, where the counter restarts from zero after reaching the compare value, which makes a square-wave frequency generator. The third is a phase-correct PWM mode, where the counter runs up to 0xFF and back down to 0x00 and the output edges fall symmetrically about the turning point. An overflow event and a compare event each latch a flag. Each flag drives an interrupt line through its own enable bit.

Counting advances on a timer tick. The tick comes from a 10-bit prescaler and a 3-bit clock selector. The prescaler is fed either by every system clock cycle or by rising edges of a slow asynchronous clock. Those edges are first passed through a flip-flop synchronizer into the system clock domain, so all state and all flags live in the bus clock domain. A small register port with four addresses gives software write and read access.

Register addresses (wr_addr/rd_addr): 0 = control, 1 = count, 2 = compare, 3 = status. Control bits: [2:0] clock select, [4:3] mode (00 overflow, 01 auto-reload, 10 phase-correct PWM, 11 behaves as overflow), [5] asynchronous source select. Status bits: [0] overflow flag, [1] compare flag, [4] overflow interrupt enable, [5] compare interrupt enable.

Top module: `tmr8_timer`

## Requirements
- R1: After reset, the control, count, compare and status registers read 0x00, and oc_out, irq_ovf and irq_cmp are low.
- R2: In overflow mode (00), each timer tick adds one to the count. The tick taken at 0xFF gives 0x00 and sets status bit 0.
- R3: The clock select picks the tick rate as follows: 001 every cycle, 010 /8, 011 /32, 100 /64, 101 /128, 110 /256, 111 /1024. The prescaler restarts whenever the select is 000. With division N, the first tick comes on the N-th enabled cycle.
- R4: With clock select 000, the count never changes except through a register write.
- R5: With control bit 5 set, the prescaler advances once per rising edge of async_clk, after a two-flop synchronizer, instead of once per system clock cycle. With select 000 those edges are ignored.
- R6: In auto-reload mode (01), a tick taken while the count equals the compare value sets the count to 0x00, sets status bit 1 and toggles oc_out. The output period is therefore 2·(compare+1) ticks.
- R7: In PWM mode (10), the count rises to 0xFF, turns to 0xFE and falls. At 0x00 it turns to 0x01 and sets status bit 0.
- R8: In PWM mode, for compare values 0x01..0xFE, a match while counting up drives oc_out low and a match while counting down drives it high. Each match sets status bit 1.
- R9: In PWM mode, a write to the compare register takes effect only when the count turns at 0xFF. In the other modes it takes effect at once.
- R10: Writing 1 to status bit 0 or 1 clears that flag. If a set event occurs in the same cycle, the set wins.
- R11: irq_ovf is high exactly when status bits 0 and 4 are both set. irq_cmp is high exactly when bits 1 and 5 are both set.
- R12: A count register write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| async_clk | input | 1 | Slow asynchronous count clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| oc_out | output | 1 | Compare waveform output |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |

## Verification
Overflow counting is driven across the 0xFF wrap at several prescaler settings, and at the synchronized slow-clock source. This separates the divide ratios from each other and confirms that stopped and async-edge ticks are counted exactly. Auto-reload runs over several periods with a small compare value, which tells toggle-per-match apart from level-per-match. PWM is walked through a full up/down period and then a second period after a mid-period compare write, which shows the up/down direction, the output polarity and the load point of the buffered compare. Same-cycle collisions (flag clear against flag set, count write against tick) pin down the priorities.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int CW = 8;
    localparam int PW = 10;

    typedef enum logic [1:0] {
        MODE_OVF   = 2'b00,
        MODE_RLD   = 2'b01,
        MODE_PWM   = 2'b10,
        MODE_RSVD  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_COUNT = 2'd1,
        ADDR_CMP   = 2'd2,
        ADDR_STAT  = 2'd3
    } addr_e;

    typedef struct packed {
        logic       async_sel;
        mode_e      mode;
        logic [2:0] csel;
    } ctrl_t;

    typedef struct packed {
        logic ovf;
        logic cmp;
    } evt_t;

    // Low-bit mask of the prescaler that must be all ones for a tick.
    function automatic logic [PW-1:0] div_mask(input logic [2:0] sel);
        case (sel)
            3'd2:    div_mask = PW'(7);
            3'd3:    div_mask = PW'(31);
            3'd4:    div_mask = PW'(63);
            3'd5:    div_mask = PW'(127);
            3'd6:    div_mask = PW'(255);
            3'd7:    div_mask = PW'(1023);
            default: div_mask = '0;
        endcase
    endfunction

endpackage

// File: rtl/tmr8_clksel.sv
module tmr8_clksel
    import tmr8_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       async_clk,
    input  logic       async_sel,
    input  logic [2:0] csel,
    output logic       tick
);
    localparam int SL = SYNC_STAGES;

    logic [SL:0]    sync_q;
    logic [PW-1:0]  pre_q;
    logic [PW-1:0]  mask;
    logic           rise;
    logic           running;
    logic           step;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SL-1:0], async_clk};
    end

    assign rise    = sync_q[SL-1] & ~sync_q[SL];
    assign running = (csel != 3'd0);
    assign step    = running && (async_sel ? rise : 1'b1);
    assign mask    = div_mask(csel);
    assign tick    = step && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !running) pre_q <= '0;
        else if (step)       pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  mode_e         mode,
    input  logic [CW-1:0] cmp_val,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    output logic [CW-1:0] count,
    output logic          oc,
    output evt_t          evt
);
    localparam logic [CW-1:0] TOP    = '1;
    localparam logic [CW-1:0] BOTTOM = '0;

    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] act_q, act_d;
    logic          up_q, up_d;
    logic          oc_q, oc_d;
    logic [CW-1:0] cmp_use;
    logic          match;

    assign cmp_use = (mode == MODE_PWM) ? act_q : cmp_val;
    assign match   = tick && (cnt_q == cmp_use);

    always_comb begin
        cnt_d   = cnt_q;
        up_d    = (mode == MODE_PWM) ? up_q : 1'b1;
        oc_d    = oc_q;
        act_d   = (mode == MODE_PWM) ? act_q : cmp_val;
        evt     = '0;
        if (cnt_we) begin
            cnt_d = cnt_wdata;
        end else if (tick) begin
            case (mode)
                MODE_RLD: begin
                    if (match) begin
                        cnt_d   = BOTTOM;
                        evt.cmp = 1'b1;
                        oc_d    = ~oc_q;
                    end else begin
                        cnt_d   = cnt_q + 1'b1;
                        evt.ovf = (cnt_q == TOP);
                    end
                end
                MODE_PWM: begin
                    if (match) begin
                        evt.cmp = 1'b1;
                        oc_d    = ~up_q;
                    end
                    if (up_q) begin
                        if (cnt_q == TOP) begin
                            cnt_d = TOP - 1'b1;
                            up_d  = 1'b0;
                            act_d = cmp_val;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end else begin
                        if (cnt_q == BOTTOM) begin
                            cnt_d   = BOTTOM + 1'b1;
                            up_d    = 1'b1;
                            evt.ovf = 1'b1;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                default: begin
                    cnt_d   = cnt_q + 1'b1;
                    evt.ovf = (cnt_q == TOP);
                    evt.cmp = match;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= '0;
            up_q  <= 1'b1;
            oc_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            act_q <= act_d;
            up_q  <= up_d;
            oc_q  <= oc_d;
        end
    end

    assign count = cnt_q;
    assign oc    = oc_q;

endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer
    import tmr8_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          async_clk,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    output logic          oc_out,
    output logic          irq_ovf,
    output logic          irq_cmp
);
    ctrl_t         ctrl_q;
    logic [CW-1:0] cmp_q;
    logic [CW-1:0] count_q;
    logic          flag_ovf_q, flag_cmp_q;
    logic          mask_ovf_q, mask_cmp_q;
    logic          tick;
    logic          cnt_we;
    logic          stat_we;
    evt_t          evt;

    assign cnt_we  = wr_en && (wr_addr == ADDR_COUNT);
    assign stat_we = wr_en && (wr_addr == ADDR_STAT);

    tmr8_clksel #(.SYNC_STAGES(SYNC_STAGES)) clksel_i (
        .clk       (clk),
        .rst       (rst),
        .async_clk (async_clk),
        .async_sel (ctrl_q.async_sel),
        .csel      (ctrl_q.csel),
        .tick      (tick)
    );

    tmr8_core core_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (ctrl_q.mode),
        .cmp_val   (cmp_q),
        .cnt_we    (cnt_we),
        .cnt_wdata (wr_data),
        .count     (count_q),
        .oc        (oc_out),
        .evt       (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            cmp_q      <= '0;
            flag_ovf_q <= 1'b0;
            flag_cmp_q <= 1'b0;
            mask_ovf_q <= 1'b0;
            mask_cmp_q <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(wr_data[5:0]);
            if (wr_en && wr_addr == ADDR_CMP)  cmp_q  <= wr_data;
            if (stat_we) begin
                mask_ovf_q <= wr_data[4];
                mask_cmp_q <= wr_data[5];
            end
            flag_ovf_q <= evt.ovf | (flag_ovf_q & ~(stat_we & wr_data[0]));
            flag_cmp_q <= evt.cmp | (flag_cmp_q & ~(stat_we & wr_data[1]));
        end
    end

    always_comb begin
        case (addr_e'(rd_addr))
            ADDR_CTRL:  rd_data = {{(CW-6){1'b0}}, ctrl_q};
            ADDR_COUNT: rd_data = count_q;
            ADDR_CMP:   rd_data = cmp_q;
            default:    rd_data = {2'b00, mask_cmp_q, mask_ovf_q, 2'b00, flag_cmp_q, flag_ovf_q};
        endcase
    end

    assign irq_ovf = flag_ovf_q & mask_ovf_q;
    assign irq_cmp = flag_cmp_q & mask_cmp_q;

endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [2:0] csel,
    input logic [1:0] mode,
    input logic       cnt_we,
    input logic [7:0] count,
    input logic [7:0] cmp_val,
    input logic       flag_ovf,
    input logic       mask_ovf,
    input logic       mask_cmp,
    input logic       irq_ovf,
    input logic       irq_cmp
);

    assert_stop_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (csel == 3'd0 && !cnt_we) |=> $stable(count));

    assert_no_tick_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        (csel == 3'd0) |-> !tick);

    assert_div8_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (csel == 3'd2 && tick) |=> (csel != 3'd2 || !tick));

    assert_ovf_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && tick && !cnt_we && count == 8'hFF) |=> (flag_ovf && count == 8'h00));

    assert_reload_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && tick && !cnt_we && count == cmp_val) |=> (count == 8'h00));

    assert_pwm_turn_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && tick && !cnt_we && count == 8'hFF) |=> (count == 8'hFE));

    assert_irq_ovf_gate_R11: assert property (@(posedge clk) disable iff (rst)
        !mask_ovf |-> !irq_ovf);

    assert_irq_cmp_gate_R11: assert property (@(posedge clk) disable iff (rst)
        !mask_cmp |-> !irq_cmp);

endmodule

bind tmr8_timer tmr8_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .csel     (ctrl_q.csel),
    .mode     (ctrl_q.mode),
    .cnt_we   (cnt_we),
    .count    (count_q),
    .cmp_val  (cmp_q),
    .flag_ovf (flag_ovf_q),
    .mask_ovf (mask_ovf_q),
    .mask_cmp (mask_cmp_q),
    .irq_ovf  (irq_ovf),
    .irq_cmp  (irq_cmp)
);

// File: tb/tmr8_timer_tb_top.sv
module tmr8_timer_tb_top;

    localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_CMP = 2'd2, A_STAT = 2'd3;
    localparam logic [7:0] M_OVF = 8'h00, M_RLD = 8'h08, M_PWM = 8'h10, ASYNC = 8'h20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       async_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       oc_out, irq_ovf, irq_cmp;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tmr8_timer dut_i (
        .clk(clk), .rst(rst), .async_clk(async_clk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .oc_out(oc_out), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // n ticks-worth of enabled cycles, ending stopped with the same mode
    task automatic run(input logic [7:0] ctrl, input int n);
        reg_wr(A_CTRL, ctrl);
        for (int i = 1; i < n; i++) @(negedge clk);
        reg_wr(A_CTRL, ctrl & 8'hF8);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        reg_rd(A_CTRL, d); chk("R1 ctrl", d, 8'h00);
        reg_rd(A_CNT, d);  chk("R1 count", d, 8'h00);
        reg_rd(A_CMP, d);  chk("R1 cmp", d, 8'h00);
        reg_rd(A_STAT, d); chk("R1 stat", d, 8'h00);
        chk("R1 pins", {oc_out, irq_ovf, irq_cmp}, 3'b000);
    endtask

    task automatic t_overflow;
        logic [7:0] d;
        reg_wr(A_CNT, 8'hFE);
        run(M_OVF | 8'h01, 2);
        reg_rd(A_CNT, d);  chk("R2 wrap count", d, 8'h00);
        reg_rd(A_STAT, d); chk("R2 ovf flag", d[0], 1'b1);
        reg_wr(A_STAT, 8'h03);
        reg_rd(A_STAT, d); chk("R10 w1c clears", d[0], 1'b0);
    endtask

    task automatic t_priority;
        logic [7:0] d;
        reg_wr(A_CNT, 8'hFF);
        reg_wr(A_CTRL, M_OVF | 8'h01);
        reg_wr(A_STAT, 8'h01);
        reg_wr(A_CTRL, M_OVF);
        reg_rd(A_STAT, d); chk("R10 set beats clear", d[0], 1'b1);
        reg_rd(A_CNT, d);  chk("R2 count after wrap", d, 8'h01);
        reg_wr(A_CTRL, M_OVF | 8'h01);
        reg_wr(A_CNT, 8'h80);
        reg_wr(A_CTRL, M_OVF);
        reg_rd(A_CNT, d);  chk("R12 write beats tick", d, 8'h81);
    endtask

    task automatic t_mask;
        reg_wr(A_STAT, 8'h00);
        chk("R11 ovf masked", irq_ovf, 1'b0);
        reg_wr(A_STAT, 8'h10);
        chk("R11 ovf enabled", irq_ovf, 1'b1);
        reg_wr(A_STAT, 8'h01);
        chk("R11 ovf cleared", irq_ovf, 1'b0);
    endtask

    task automatic t_stop;
        logic [7:0] d;
        reg_wr(A_CNT, 8'h33);
        repeat (20) @(negedge clk);
        reg_rd(A_CNT, d); chk("R4 stopped holds", d, 8'h33);
    endtask

    task automatic t_prescale;
        logic [7:0] d;
        reg_wr(A_CNT, 8'h00);
        run(M_OVF | 8'h02, 20);
        reg_rd(A_CNT, d); chk("R3 div8", d, 8'h02);
        run(M_OVF | 8'h04, 130);
        reg_rd(A_CNT, d); chk("R3 div64", d, 8'h04);
        run(M_OVF | 8'h07, 1023);
        reg_rd(A_CNT, d); chk("R3 div1024 early", d, 8'h04);
        run(M_OVF | 8'h07, 1024);
        reg_rd(A_CNT, d); chk("R3 div1024", d, 8'h05);
    endtask

    task automatic async_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            async_clk = 1'b1;
            repeat (5) @(negedge clk);
            async_clk = 1'b0;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic t_async;
        logic [7:0] d;
        reg_wr(A_CNT, 8'h00);
        reg_wr(A_CTRL, ASYNC | M_OVF | 8'h01);
        repeat (5) @(negedge clk);
        async_pulses(5);
        repeat (6) @(negedge clk);
        reg_wr(A_CTRL, ASYNC | M_OVF);
        reg_rd(A_CNT, d); chk("R5 async edges counted", d, 8'h05);
        async_pulses(3);
        reg_rd(A_CNT, d); chk("R5 async stopped", d, 8'h05);
        reg_wr(A_CTRL, M_OVF);
    endtask

    task automatic t_reload;
        logic [7:0] d;
        reg_wr(A_CMP, 8'h03);
        reg_wr(A_CNT, 8'h00);
        reg_wr(A_CTRL, M_RLD);
        reg_wr(A_STAT, 8'h03);
        run(M_RLD | 8'h01, 4);
        reg_rd(A_CNT, d);  chk("R6 reload count", d, 8'h00);
        chk("R6 first toggle", oc_out, 1'b1);
        reg_rd(A_STAT, d); chk("R6 cmp flag, no ovf", d[1:0], 2'b10);
        run(M_RLD | 8'h01, 3);
        chk("R6 no toggle before match", oc_out, 1'b1);
        run(M_RLD | 8'h01, 1);
        chk("R6 second toggle", oc_out, 1'b0);
        reg_wr(A_STAT, 8'h22);
        chk("R11 cmp irq after clear", irq_cmp, 1'b0);
    endtask

    task automatic t_pwm;
        logic [7:0] d;
        reg_wr(A_CTRL, M_OVF);
        reg_wr(A_CMP, 8'h40);
        reg_wr(A_CNT, 8'h00);
        reg_wr(A_CTRL, M_PWM);
        reg_wr(A_STAT, 8'h03);
        run(M_PWM | 8'h01, 8'h41);
        reg_rd(A_CNT, d);  chk("R7 up count", d, 8'h41);
        chk("R8 up match clears", oc_out, 1'b0);
        reg_rd(A_STAT, d); chk("R8 cmp flag", d[1], 1'b1);
        run(M_PWM | 8'h01, 8'hBE);
        reg_rd(A_CNT, d);  chk("R7 reach top", d, 8'hFF);
        run(M_PWM | 8'h01, 1);
        reg_rd(A_CNT, d);  chk("R7 turn at top", d, 8'hFE);
        run(M_PWM | 8'h01, 8'hBE);
        reg_rd(A_CNT, d);  chk("R7 down count", d, 8'h40);
        chk("R8 no set before match", oc_out, 1'b0);
        run(M_PWM | 8'h01, 1);
        chk("R8 down match sets", oc_out, 1'b1);
        reg_wr(A_STAT, 8'h03);
        run(M_PWM | 8'h01, 8'h40);
        reg_rd(A_CNT, d);  chk("R7 turn at bottom", d, 8'h01);
        reg_rd(A_STAT, d); chk("R7 ovf at bottom", d[0], 1'b1);
        run(M_PWM | 8'h01, 1);
        reg_rd(A_CNT, d);  chk("R7 up again", d, 8'h02);
    endtask

    task automatic t_pwm_buffer;
        logic [7:0] d;
        reg_wr(A_CMP, 8'h60);
        run(M_PWM | 8'h01, 8'h3F);
        reg_rd(A_CNT, d);  chk("R9 count", d, 8'h41);
        chk("R9 old compare still active", oc_out, 1'b0);
        run(M_PWM | 8'h01, 8'hBE);
        run(M_PWM | 8'h01, 1);
        reg_rd(A_CNT, d);  chk("R9 at top turn", d, 8'hFE);
        run(M_PWM | 8'h01, 8'h9D);
        chk("R9 before new match", oc_out, 1'b0);
        run(M_PWM | 8'h01, 2);
        reg_rd(A_CNT, d);  chk("R9 count after new match", d, 8'h5F);
        chk("R9 new compare loaded at top", oc_out, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_overflow();
        t_priority();
        t_mask();
        t_stop();
        t_prescale();
        t_async();
        t_reload();
        t_pwm();
        t_pwm_buffer();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule